// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath takes several short clock cycles per instruction and reuses one ALU and one memory port in different cycles. It is a Moore-style state machine with ten numbered states. Two of them are shared by every instruction: an instruction fetch state that also advances the program counter, and a decode state that reads the register operands and uses the otherwise idle ALU to compute the branch target early. After decode the machine branches into a short chain of states for the instruction's class (register-register arithmetic, load word, store word, branch-if-equal, jump). Each chain returns to fetch when it is done.

The inputs are the 6-bit opcode, taken from the instruction register, and the ALU zero flag. The outputs are the datapath enables and multiplexer selects. The only output that also depends on an input is the program-counter load in the branch state: there it follows the zero flag. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level that the datapath samples at the next rising clock edge. The current state number is also brought out as a port.

Top module: `mcyc_ctrl_fsm`

## Requirements
- R1: While reset is held, and in the cycle after it, the state is Fetch (0). In Fetch the outputs are: memory read from the program counter address (addr_sel=0), instruction register load, program counter load from the ALU result (pc_src=0), and ALU computing PC + 4 (alu_a=0, alu_b=1, alu_op=0 add). The next state is Decode (1).
- R2: Decode (1) writes nothing and drives alu_a=0 (PC), alu_b=3 (shifted sign-extended immediate) and alu_op=0. The next state comes from the opcode: 0x00 goes to 6, 0x23 and 0x2B go to 2, 0x04 goes to 8, 0x02 goes to 9.
- R3: State 2 drives alu_a=1 (register A), alu_b=2 (sign-extended immediate) and alu_op=0. The next state is 3 for opcode 0x23 and 5 for opcode 0x2B.
- R4: State 3 drives a memory read with addr_sel=1 (ALU output register) and goes to 4. State 4 drives register write with rf_dst=0 (Rt) and wb_src=1 (memory data register) and goes to Fetch.
- R5: State 5 drives a memory write with addr_sel=1 and goes to Fetch.
- R6: State 6 drives alu_a=1, alu_b=0 (register B) and alu_op=2 (function field decides) and goes to 7. State 7 drives register write with rf_dst=1 (Rd) and wb_src=0 (ALU output register) and goes to Fetch.
- R7: State 8 drives alu_a=1, alu_b=0, alu_op=1 (subtract) and pc_src=1 (ALU output register). pc_ld equals the zero flag. The next state is Fetch.
- R8: State 9 drives pc_ld with pc_src=2 (jump target) and goes to Fetch.
- R9: From Fetch back to Fetch an instruction takes 4 cycles for R-type, 5 for load, 4 for store, 3 for branch and 3 for jump.
- R10: Any other opcode returns from Decode straight to Fetch (2 cycles), with no register, memory or program counter write in between.
- R11: In every state, each enable and select not named for that state in R1 to R8 is 0. Register write occurs only in states 4 and 7, and memory write only in state 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| state_o | output | 4 | Current state number 0 to 9 |
| pc_ld_o | output | 1 | Program counter load enable |
| pc_src_o | output | 2 | PC source: 0 ALU result, 1 ALU output register, 2 jump target |
| ir_ld_o | output | 1 | Instruction register load enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| rf_wr_o | output | 1 | Register file write enable |
| rf_dst_o | output | 1 | Destination register: 0 Rt, 1 Rd |
| wb_src_o | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| alu_a_o | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_o | output | 2 | ALU B input: 0 register B, 1 constant 4, 2 immediate, 3 immediate shifted left 2 |
| alu_op_o | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |

## Verification
The assertions assume that the opcode comes from the instruction register. It therefore stays fixed from Decode until the machine is back in Fetch, and it changes only on the edge that leaves Fetch. The zero flag matters only in state 8. The stimulus follows this rule: it changes the opcode and zero flag only while the machine is in Fetch, and holds them for the whole instruction. The runs cover every class, both outcomes of the branch, unknown opcodes, and instructions issued back to back.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LOAD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STORE  = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } st_e;

  typedef enum logic [2:0] {
    C_RTYPE, C_LOAD, C_STORE, C_BEQ, C_JUMP, C_NONE
  } cls_e;

  localparam logic [1:0] ALUB_REG   = 2'd0;
  localparam logic [1:0] ALUB_FOUR  = 2'd1;
  localparam logic [1:0] ALUB_IMM   = 2'd2;
  localparam logic [1:0] ALUB_IMMSH = 2'd3;

  localparam logic [1:0] ALUOP_ADD  = 2'd0;
  localparam logic [1:0] ALUOP_SUB  = 2'd1;
  localparam logic [1:0] ALUOP_FUNC = 2'd2;

  localparam logic [1:0] PCS_ALU    = 2'd0;
  localparam logic [1:0] PCS_OUT    = 2'd1;
  localparam logic [1:0] PCS_JMP    = 2'd2;

  typedef struct packed {
    logic       pc_ld;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       ir_ld;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       rf_wr;
    logic       rf_dst;
    logic       wb_src;
    logic       alu_a;
    logic [1:0] alu_b;
    logic [1:0] alu_op;
  } ctl_t;

endpackage

// File: rtl/mcyc_ctrl_opclass.sv
module mcyc_ctrl_opclass
  import mcyc_ctrl_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_RTYPE = 6'h00,
  parameter logic [OPW-1:0]  OP_LW    = 6'h23,
  parameter logic [OPW-1:0]  OP_SW    = 6'h2B,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_J     = 6'h02
) (
  input  logic [OPW-1:0] opcode,
  output cls_e           cls
);

  always_comb begin
    if (opcode == OP_RTYPE)     cls = C_RTYPE;
    else if (opcode == OP_LW)   cls = C_LOAD;
    else if (opcode == OP_SW)   cls = C_STORE;
    else if (opcode == OP_BEQ)  cls = C_BEQ;
    else if (opcode == OP_J)    cls = C_JUMP;
    else                        cls = C_NONE;
  end

endmodule

// File: rtl/mcyc_ctrl_next.sv
module mcyc_ctrl_next
  import mcyc_ctrl_pkg::*;
(
  input  st_e  cur,
  input  cls_e cls,
  output st_e  nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (cls)
          C_RTYPE:         nxt = S_EXEC;
          C_LOAD, C_STORE: nxt = S_ADDR;
          C_BEQ:           nxt = S_BRANCH;
          C_JUMP:          nxt = S_JUMP;
          default:         nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (cls == C_STORE) ? S_STORE : S_LOAD;
      S_LOAD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_outdec.sv
module mcyc_ctrl_outdec
  import mcyc_ctrl_pkg::*;
(
  input  st_e  cur,
  output ctl_t ctl
);

  always_comb begin
    ctl = '0;
    unique case (cur)
      S_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.pc_ld  = 1'b1;
        ctl.pc_src = PCS_ALU;
        ctl.alu_b  = ALUB_FOUR;
        ctl.alu_op = ALUOP_ADD;
      end
      S_DECODE: begin
        ctl.alu_b  = ALUB_IMMSH;
        ctl.alu_op = ALUOP_ADD;
      end
      S_ADDR: begin
        ctl.alu_a  = 1'b1;
        ctl.alu_b  = ALUB_IMM;
        ctl.alu_op = ALUOP_ADD;
      end
      S_LOAD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.rf_dst = 1'b0;
        ctl.wb_src = 1'b1;
      end
      S_STORE: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a  = 1'b1;
        ctl.alu_b  = ALUB_REG;
        ctl.alu_op = ALUOP_FUNC;
      end
      S_RWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.rf_dst = 1'b1;
        ctl.wb_src = 1'b0;
      end
      S_BRANCH: begin
        ctl.alu_a   = 1'b1;
        ctl.alu_b   = ALUB_REG;
        ctl.alu_op  = ALUOP_SUB;
        ctl.pc_cond = 1'b1;
        ctl.pc_src  = PCS_OUT;
      end
      S_JUMP: begin
        ctl.pc_ld  = 1'b1;
        ctl.pc_src = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_fsm.sv
module mcyc_ctrl_fsm
  import mcyc_ctrl_pkg::*;
#(
  parameter int              OPW      = 6,
  parameter logic [OPW-1:0]  OP_RTYPE = 6'h00,
  parameter logic [OPW-1:0]  OP_LW    = 6'h23,
  parameter logic [OPW-1:0]  OP_SW    = 6'h2B,
  parameter logic [OPW-1:0]  OP_BEQ   = 6'h04,
  parameter logic [OPW-1:0]  OP_J     = 6'h02
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode_i,
  input  logic           alu_zero_i,
  output logic [3:0]     state_o,
  output logic           pc_ld_o,
  output logic [1:0]     pc_src_o,
  output logic           ir_ld_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           addr_sel_o,
  output logic           rf_wr_o,
  output logic           rf_dst_o,
  output logic           wb_src_o,
  output logic           alu_a_o,
  output logic [1:0]     alu_b_o,
  output logic [1:0]     alu_op_o
);

  st_e  state_q, state_d;
  cls_e cls;
  ctl_t ctl;

  mcyc_ctrl_opclass #(
    .OPW(OPW), .OP_RTYPE(OP_RTYPE), .OP_LW(OP_LW),
    .OP_SW(OP_SW), .OP_BEQ(OP_BEQ), .OP_J(OP_J)
  ) u_opclass (
    .opcode (opcode_i),
    .cls    (cls)
  );

  mcyc_ctrl_next u_next (
    .cur (state_q),
    .cls (cls),
    .nxt (state_d)
  );

  mcyc_ctrl_outdec u_outdec (
    .cur (state_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign pc_ld_o    = ctl.pc_ld | (ctl.pc_cond & alu_zero_i);
  assign pc_src_o   = ctl.pc_src;
  assign ir_ld_o    = ctl.ir_ld;
  assign mem_rd_o   = ctl.mem_rd;
  assign mem_wr_o   = ctl.mem_wr;
  assign addr_sel_o = ctl.addr_sel;
  assign rf_wr_o    = ctl.rf_wr;
  assign rf_dst_o   = ctl.rf_dst;
  assign wb_src_o   = ctl.wb_src;
  assign alu_a_o    = ctl.alu_a;
  assign alu_b_o    = ctl.alu_b;
  assign alu_op_o   = ctl.alu_op;

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH) |=> (state_q == S_DECODE)); // R1
  AST_DECODE_LW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DECODE && opcode_i == OP_LW) |=> (state_q == S_ADDR)); // R2
  AST_ADDR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR) |=> (state_q == S_LOAD || state_q == S_STORE)); // R3
  AST_LOAD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOAD) |=> (state_q == S_LDWB && rf_wr_o && wb_src_o)); // R4
  AST_STORE_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STORE) |=> (state_q == S_FETCH)); // R5
  AST_EXEC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_EXEC) |=> (state_q == S_RWB && rf_dst_o)); // R6
  AST_BRANCH_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BRANCH) |=> (state_q == S_FETCH)); // R7
  AST_JUMP_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_JUMP) |=> (state_q == S_FETCH && ir_ld_o)); // R8
  AST_BAD_OP_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DECODE && cls == C_NONE) |=> (state_q == S_FETCH)); // R10
  AST_RFWR_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_o |-> (state_q == S_LDWB || state_q == S_RWB)); // R11
  AST_MEMWR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (state_q == S_STORE && !mem_rd_o)); // R11

endmodule

// File: tb/mcyc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mcyc_ctrl_fsm_bench;

  localparam real CLK_NS = 4.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic       zero = 1'b0;
  logic [3:0] state_o;
  logic       pc_ld_o, ir_ld_o, mem_rd_o, mem_wr_o, addr_sel_o;
  logic       rf_wr_o, rf_dst_o, wb_src_o, alu_a_o;
  logic [1:0] pc_src_o, alu_b_o, alu_op_o;

  int n_run = 0;
  int n_fail = 0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  mcyc_ctrl_fsm u_mcyc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .alu_zero_i(zero),
    .state_o(state_o), .pc_ld_o(pc_ld_o), .pc_src_o(pc_src_o),
    .ir_ld_o(ir_ld_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .addr_sel_o(addr_sel_o), .rf_wr_o(rf_wr_o), .rf_dst_o(rf_dst_o),
    .wb_src_o(wb_src_o), .alu_a_o(alu_a_o), .alu_b_o(alu_b_o),
    .alu_op_o(alu_op_o)
  );

  // Order: state, pc_ld, pc_src, ir_ld, mem_rd, mem_wr, addr_sel,
  // rf_wr, rf_dst, wb_src, alu_a, alu_b, alu_op
  function automatic logic [18:0] pack(logic [3:0] st, logic pl, logic [1:0] ps,
      logic ir, logic mr, logic mw, logic as, logic rw, logic rd, logic wb,
      logic aa, logic [1:0] ab, logic [1:0] ao);
    return {st, pl, ps, ir, mr, mw, as, rw, rd, wb, aa, ab, ao};
  endfunction

  function automatic logic [18:0] expv(int st, logic z);
    case (st)
      0: return pack(4'd0, 1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 0, 2'd1, 2'd0);
      1: return pack(4'd1, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 2'd0);
      2: return pack(4'd2, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 2'd0);
      3: return pack(4'd3, 0, 2'd0, 0, 1, 0, 1, 0, 0, 0, 0, 2'd0, 2'd0);
      4: return pack(4'd4, 0, 2'd0, 0, 0, 0, 0, 1, 0, 1, 0, 2'd0, 2'd0);
      5: return pack(4'd5, 0, 2'd0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd0, 2'd0);
      6: return pack(4'd6, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd2);
      7: return pack(4'd7, 0, 2'd0, 0, 0, 0, 0, 1, 1, 0, 0, 2'd0, 2'd0);
      8: return pack(4'd8, z, 2'd1, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd1);
      default: return pack(4'd9, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0);
    endcase
  endfunction

  function automatic logic [18:0] actual();
    return pack(state_o, pc_ld_o, pc_src_o, ir_ld_o, mem_rd_o, mem_wr_o,
                addr_sel_o, rf_wr_o, rf_dst_o, wb_src_o, alu_a_o, alu_b_o, alu_op_o);
  endfunction

  task automatic push(int st, logic z, string tag);
    exp_q.push_back(expv(st, z));
    tag_q.push_back(tag);
  endtask

  // Driver: called at a negedge while the design sits in Fetch.
  task automatic issue(logic [5:0] op, logic z);
    int len;
    opcode = op;
    zero   = z;
    push(0, z, "R1 fetch");
    push(1, z, "R2 decode");
    case (op)
      6'h00: begin push(6, z, "R6 exec"); push(7, z, "R6 rd-writeback R9 len4"); len = 4; end
      6'h23: begin push(2, z, "R3 addr"); push(3, z, "R4 load");
                   push(4, z, "R4 rt-writeback R9 len5"); len = 5; end
      6'h2B: begin push(2, z, "R3 addr"); push(5, z, "R5 store R9 len4"); len = 4; end
      6'h04: begin push(8, z, "R7 branch R9 len3"); len = 3; end
      6'h02: begin push(9, z, "R8 jump R9 len3"); len = 3; end
      default: len = 2; // R10 back to Fetch after decode
    endcase
    repeat (len) @(negedge clk);
  endtask

  // Monitor: samples 1 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (actual() !== e) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", t, actual(), e);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_run++;
    if (actual() !== expv(0, 0)) begin // R1 reset state
      n_fail++;
      $display("FAIL R1 reset: actual %b expected %b", actual(), expv(0, 0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    issue(6'h00, 0);
    issue(6'h23, 0);
    issue(6'h2B, 1);
    issue(6'h04, 1);   // R7 taken
    issue(6'h04, 0);   // R7 not taken
    issue(6'h02, 0);
    issue(6'h3F, 1);   // R10 unknown
    issue(6'h08, 0);   // R10 unknown
    issue(6'h2B, 0);
    issue(6'h23, 1);
    issue(6'h00, 1);
    issue(6'h04, 1);
    issue(6'h02, 1);
    issue(6'h00, 0);
    @(negedge clk);
    #2;
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 queue drain: actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule